// File: doc/BRIEF.md
# Fixed-Point Multiply-Round-Shift Unit

This block is a small pipelined datapath for fixed-point signal processing kernels such as transforms, filters and audio decoders. It takes two signed operands, forms their exact product, adds half of the weight of the bits about to be dropped, and shifts the sum arithmetically to the right. The result is the product scaled down by a power of two and rounded to the nearest value, where plain truncation would always round toward minus infinity.

The shift amount arrives as a small immediate field that goes with each operation. A narrow mode reads only the low half of each operand as a signed 16-bit value. A wide mode uses full signed 32-bit operands. Both modes return a signed 32-bit result. Operations can be issued back to back on consecutive cycles. Each result appears two clock edges after its request and is marked by a one-cycle valid flag.

Top module: `mrs_unit`

## Requirements
- R1: While reset is asserted, and for the two synchronizing cycles after it is released, `out_valid` is 0 and `result` is 0.
- R2: When `mode_wide` is 0, `op_a[15:0]` and `op_b[15:0]` are taken as signed 16-bit values, and `op_a[31:16]` and `op_b[31:16]` have no effect on the result.
- R3: When `mode_wide` is 1, `op_a` and `op_b` are signed 32-bit values. The full 64-bit product is formed before rounding and shifting, and `result` is bits [31:0] of the shifted value.
- R4: For `shamt` = s with s in 1..31, `result` equals (a*b + 2^(s-1)) shifted right by s, so an exact half rounds up toward plus infinity.
- R5: For `shamt` = 0 no rounding term is added, and `result` is bits [31:0] of the product.
- R6: The right shift is arithmetic, so a negative sum keeps its sign in the result. In narrow mode a negative result occurs only when the operands have opposite signs.
- R7: A request that `in_valid` marks at a clock edge gives `out_valid` = 1 for exactly one cycle after the second following edge. Requests on consecutive cycles give results on consecutive cycles, in issue order.
- R8: `result` does not change in any cycle where `out_valid` is 0, whatever the inputs do while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks a request in this cycle |
| mode_wide | input | 1 | 0: signed 16-bit operands in bits [15:0]; 1: signed 32-bit operands |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| shamt | input | 5 | Immediate right-shift amount, 0 to 31 |
| out_valid | output | 1 | One-cycle flag marking a new result |
| result | output | 32 | Rounded and shifted product, signed |

## Verification
Narrow mode is swept over a grid of 16-bit corner values (both extremes, ±1, 0 and odd values) crossed with all 32 shift amounts. Products that are exact halves show whether rounding goes up or down. The most negative pair shows whether the product sign is handled correctly. Wide mode repeats the grid with 32-bit extremes, so a product that does not fit in 32 bits shows whether the 64-bit intermediate is kept. Narrow requests with random upper operand bits show whether those bits leak into the result. Idle gaps, during which the operands keep changing, separate a result register that holds its value from one that follows its inputs. A continuous stream of requests checks that the latency is fixed and that results come out in issue order.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned SHIFT_W  = $clog2(DATA_W);
  localparam int unsigned PROD_W   = 2 * DATA_W;

  typedef logic signed [DATA_W-1:0] word_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic        [SHIFT_W-1:0] shamt_t;
endpackage

// File: rtl/mrs_operand_fmt.sv
module mrs_operand_fmt #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic                     mode_wide,
  input  logic        [DATA_W-1:0] raw_a,
  input  logic        [DATA_W-1:0] raw_b,
  output logic signed [DATA_W-1:0] ext_a,
  output logic signed [DATA_W-1:0] ext_b
);
  localparam int unsigned PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] nar_a;
  logic [DATA_W-1:0] nar_b;

  generate
    if (PAD_W > 0) begin : g_pad
      assign nar_a = {{PAD_W{raw_a[NARROW_W-1]}}, raw_a[NARROW_W-1:0]};
      assign nar_b = {{PAD_W{raw_b[NARROW_W-1]}}, raw_b[NARROW_W-1:0]};
    end else begin : g_nopad
      assign nar_a = raw_a;
      assign nar_b = raw_b;
    end
  endgenerate

  always_comb begin
    if (mode_wide) begin
      ext_a = raw_a;
      ext_b = raw_b;
    end else begin
      ext_a = nar_a;
      ext_b = nar_b;
    end
  end
endmodule

// File: rtl/mrs_mult_stage.sv
module mrs_mult_stage #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [DATA_W-1:0]   ext_a,
  input  logic signed [DATA_W-1:0]   ext_b,
  input  logic        [SHIFT_W-1:0]  shamt,
  output logic                       s1_valid,
  output logic signed [2*DATA_W-1:0] s1_prod,
  output logic        [SHIFT_W-1:0]  s1_shamt
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod_d;
  logic signed [PROD_W-1:0] prod_q;
  logic [SHIFT_W-1:0]       shamt_q;
  logic                     valid_q;
  logic                     load_en;

  always_comb begin
    load_en = in_valid;
    prod_d  = PROD_W'(ext_a) * PROD_W'(ext_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      shamt_q <= '0;
    end else if (load_en) begin
      prod_q  <= prod_d;
      shamt_q <= shamt;
    end
  end

  assign s1_valid = valid_q;
  assign s1_prod  = prod_q;
  assign s1_shamt = shamt_q;
endmodule

// File: rtl/mrs_round_shift.sv
module mrs_round_shift #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_valid,
  input  logic signed [2*DATA_W-1:0] s1_prod,
  input  logic        [SHIFT_W-1:0]  s1_shamt,
  output logic                       s2_valid,
  output logic        [DATA_W-1:0]   s2_result
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] bias;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;
  logic [DATA_W-1:0]        res_d;
  logic [DATA_W-1:0]        res_q;
  logic                     valid_q;

  always_comb begin
    if (s1_shamt == '0) begin
      bias = '0;
    end else begin
      bias = PROD_W'(1) << (s1_shamt - SHIFT_W'(1));
    end
    biased  = s1_prod + bias;
    shifted = biased >>> s1_shamt;
    res_d   = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= s1_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (s1_valid) begin
      res_q <= res_d;
    end
  end

  assign s2_valid  = valid_q;
  assign s2_result = res_q;
endmodule

// File: rtl/mrs_unit.sv
module mrs_unit
  import mrs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                mode_wide,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [SHIFT_W-1:0]  shamt,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  word_t      ext_a;
  word_t      ext_b;
  logic       s1_valid;
  prod_t      s1_prod;
  shamt_t     s1_shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  mrs_operand_fmt #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_fmt (
    .mode_wide (mode_wide),
    .raw_a     (op_a),
    .raw_b     (op_b),
    .ext_a     (ext_a),
    .ext_b     (ext_b)
  );

  mrs_mult_stage #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .ext_a    (ext_a),
    .ext_b    (ext_b),
    .shamt    (shamt),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_shamt (s1_shamt)
  );

  mrs_round_shift #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_rnd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .s1_valid  (s1_valid),
    .s1_prod   (s1_prod),
    .s1_shamt  (s1_shamt),
    .s2_valid  (out_valid),
    .s2_result (result)
  );
endmodule

// File: rtl/mrs_unit_chk.sv
module mrs_unit_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        in_valid,
  input logic        mode_wide,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic [31:0] result
);
  // R1: nothing leaves the block while the internal reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && result == 32'd0));

  // R7: every request produces a flag two edges later
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> ##2 out_valid);

  // R7: no flag without a request two edges earlier
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(in_valid, 2));

  // R8: result holds between results
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> $stable(result));

  // R4: a zero operand rounds to zero for every shift
  a_r4_zero_product: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && $past(in_valid && (op_a == 32'd0 || op_b == 32'd0), 2))
      |-> result == 32'd0);

  // R6: in narrow mode a negative result needs operands of opposite sign
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && result[31] && $past(in_valid && !mode_wide, 2))
      |-> $past(op_a[15] ^ op_b[15], 2));
endmodule

bind mrs_unit mrs_unit_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .mode_wide  (mode_wide),
  .op_a       (op_a),
  .op_b       (op_b),
  .out_valid  (out_valid),
  .result     (result)
);

// File: tb/tb_mrs_unit.sv
`timescale 1ns/1ps
module tb_mrs_unit;
  localparam int QMAX = 8192;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        mode_wide;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [4:0]  shamt;
  logic        out_valid;
  logic [31:0] result;

  mrs_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_wide (mode_wide),
    .op_a      (op_a),
    .op_b      (op_b),
    .shamt     (shamt),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          n_checks;
  int          n_fail;
  int          cyc;
  int          n_issued;
  int          n_seen;
  logic [31:0] exp_q [QMAX];
  int          cyc_q [QMAX];
  string       tag_q [QMAX];
  logic [31:0] last_res;
  logic        mon_on;
  logic        done;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] model(input logic wide, input logic [31:0] a,
                                        input logic [31:0] b, input int s);
    longint pa;
    longint pb;
    longint sum;
    if (wide) begin
      pa = longint'($signed(a));
      pb = longint'($signed(b));
    end else begin
      pa = longint'($signed(a[15:0]));
      pb = longint'($signed(b[15:0]));
    end
    sum = pa * pb;
    if (s != 0) sum = sum + (longint'(1) << (s - 1));
    sum = sum >>> s;
    return sum[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor on the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (n_seen >= n_issued) begin
          check("R7 unexpected out_valid", 32'd1, 32'd0);
        end else begin
          check(tag_q[n_seen], result, exp_q[n_seen]);
          check("R7 latency", 32'(cyc - cyc_q[n_seen]), 32'd2);
          n_seen++;
        end
      end else begin
        check("R8 hold while idle", result, last_res);
      end
      last_res = result;
    end
  end

  task automatic issue(input string tag, input logic wide, input logic [31:0] a,
                       input logic [31:0] b, input int s);
    @(negedge clk);
    in_valid  = 1'b1;
    mode_wide = wide;
    op_a      = a;
    op_b      = b;
    shamt     = 5'(s);
    exp_q[n_issued] = model(wide, a, b, s);
    cyc_q[n_issued] = cyc;
    tag_q[n_issued] = tag;
    n_issued++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      mode_wide = $urandom_range(0, 1) == 1;
      op_a      = $urandom;
      op_b      = $urandom;
      shamt     = 5'($urandom_range(0, 31));
    end
  endtask

  task automatic drain;
    idle(4);
    check("R7 all results returned", 32'(n_seen), 32'(n_issued));
  endtask

  logic [31:0] nvals [9];
  logic [31:0] wvals [8];

  initial begin
    n_checks = 0; n_fail = 0; cyc = 0; n_issued = 0; n_seen = 0;
    mon_on = 1'b0; done = 1'b0; last_res = '0;
    rst_n = 1'b0; in_valid = 1'b0; mode_wide = 1'b0;
    op_a = '0; op_b = '0; shamt = '0;
    nvals = '{32'hFFFF8000, 32'hFFFF8001, 32'hFFFFFFFF, 32'h0, 32'h1,
              32'h3, 32'h7FFF, 32'hFFFFFFFB, 32'h3039};
    wvals = '{32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h1,
              32'h00010000, 32'hDEADBEEF, 32'h12345679};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 result in reset", result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    last_res = result;
    mon_on = 1'b1;

    // R4/R6: directed rounding of exact halves
    issue("R4 +3 shr1", 1'b0, 32'd3, 32'd1, 1);
    issue("R4 -3 shr1", 1'b0, 32'hFFFFFFFD, 32'd1, 1);
    issue("R6 -1 shr1", 1'b0, 32'hFFFFFFFF, 32'd1, 1);
    issue("R6 -5 shr2", 1'b0, 32'hFFFFFFFB, 32'd1, 2);
    issue("R4 q15 half", 1'b0, 32'h4000, 32'h4000, 16);
    idle(3);

    // narrow sweep: all shifts against corner grid
    for (int s = 0; s < 32; s++) begin
      for (int i = 0; i < 9; i++) begin
        for (int j = 0; j < 9; j++) begin
          if (s == 0)
            issue("R5 shift zero", 1'b0, nvals[i], nvals[j], s);
          else if (nvals[i][15] ^ nvals[j][15])
            issue("R6 narrow negative", 1'b0, nvals[i], nvals[j], s);
          else
            issue("R2 narrow", 1'b0, nvals[i], nvals[j], s);
        end
      end
      if (s % 4 == 3) idle(2);
    end
    drain();

    // wide sweep
    for (int s = 0; s < 32; s++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          if (s == 0)
            issue("R5 wide shift zero", 1'b1, wvals[i], wvals[j], s);
          else
            issue("R3 wide", 1'b1, wvals[i], wvals[j], s);
        end
      end
      if (s % 4 == 1) idle(3);
    end
    drain();

    // R2: upper operand bits ignored in narrow mode
    for (int k = 0; k < 256; k++) begin
      issue("R2 upper bits ignored", 1'b0, $urandom, $urandom, $urandom_range(0, 31));
      if (k % 16 == 15) idle(1);
    end
    drain();

    mon_on = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule